// File: doc/BRIEF.md
# HDLC Status and Interrupt Register

This block collects status for an HDLC controller into one 16-bit register. It also turns that register into a single interrupt line. Six of the bits latch one-cycle event pulses from the transmit and receive engines. A read of the status register clears them. The remaining bits are level indications, recomputed every cycle from the FIFO fill counts and the two 3-bit watermark settings.

A 16-bit interrupt mask register is written and read through the same port. A status bit raises the interrupt only when its mask bit is 1 and the global HDLC enable input is also 1. Software reads the status register to learn the cause. That read releases the interrupt held by any latched bit.

Port select values: `reg_sel_i` = 0 addresses the status register and 1 addresses the mask register. `rdata_o` always shows the selected register, whether or not a read strobe is given. Only a strobed read of the status register clears bits.

Top module: `hdlc_irq_status`

## Requirements
- R1: Status bit positions are fixed. Bit 0 is transmit end and bit 2 is transmit low watermark. Bit 4 is receive high watermark, bit 5 receive start, bit 6 receive end and bit 7 transmit underrun. Bits 11:8 hold the transmit fill field. Bit 12 is transmit empty, bit 13 receive overrun, bit 14 receive empty and bit 15 receive abort. Bits 3 and 1 always read 0.
- R2: During reset the status register reads 16'h5004, the mask register reads 0 and `irq_o` is 0.
- R3: Bit 0 sets one cycle after a transmit end pulse or a transmit underrun pulse. Bit 7 sets one cycle after an underrun pulse.
- R4: Bits 5, 6, 13 and 15 set one cycle after the receive start, receive end, receive overrun and receive abort pulses, respectively. Bit 6 sets for every receive end pulse; the engine gives no CRC outcome to the block.
- R5: A read strobe with `reg_sel_i`=0 returns the pre-clear value in the same cycle. From the next cycle, every latched bit (0, 5, 6, 7, 13, 15) reads 0 until a new event arrives.
- R6: An event pulse in the same cycle as a clearing read leaves its bit set.
- R7: One cycle after the inputs, bit 2 is 1 exactly when `tx_cnt_i` < `tx_wm_sel_i` × WM_STEP (default step 16).
- R8: One cycle after the inputs, bit 4 is 1 exactly when `rx_cnt_i` > `rx_wm_sel_i` × WM_STEP.
- R9: One cycle after the inputs, bit 12 shows `tx_cnt_i`==0, bit 14 shows `rx_cnt_i`==0, and bits 11:8 hold the top four bits of `tx_cnt_i`.
- R10: `irq_o` is 1 in the cycle after one in which `hdlc_en_i` is 1 and some status bit is 1 together with its mask bit. Otherwise `irq_o` is 0.
- R11: When the only qualifying bit is latched and is cleared by a read, `irq_o` falls two cycles after the read.
- R12: A write with `reg_sel_i`=1 loads the mask register. A write with `reg_sel_i`=0 has no effect on either register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_sel_i | input | 1 | 0 selects status, 1 selects mask |
| we_i | input | 1 | Write strobe |
| re_i | input | 1 | Read strobe (clears status on sel 0) |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Selected register contents |
| tx_end_evt_i | input | 1 | Transmitter consumed an end-of-message byte |
| tx_udr_evt_i | input | 1 | Transmit FIFO underrun |
| rx_start_evt_i | input | 1 | Opening byte of a received packet |
| rx_end_evt_i | input | 1 | Received packet finished |
| rx_ovr_evt_i | input | 1 | Receive FIFO overrun |
| rx_abt_evt_i | input | 1 | Received abort sequence |
| tx_cnt_i | input | CNT_W | Transmit FIFO fill |
| rx_cnt_i | input | CNT_W | Receive FIFO fill |
| tx_wm_sel_i | input | 3 | Transmit low watermark setting |
| rx_wm_sel_i | input | 3 | Receive high watermark setting |
| hdlc_en_i | input | 1 | Global HDLC interrupt enable |
| irq_o | output | 1 | Interrupt request |

## Verification
A latched bit that sets late, or not at all, shows at `rdata_o` one cycle after the pulse. A latched bit that fails to clear shows the cycle after a read. A lost event during a read-clear collision shows in that same next cycle. Errors in the watermark comparison appear one cycle after the counts change, so sweeping counts across each threshold exposes off-by-one mistakes directly. Gating errors appear on `irq_o` two cycles after the stimulus, one cycle behind the status they derive from.

// File: rtl/hdlc_stat_pkg.sv
package hdlc_stat_pkg;
  localparam int STAT_W = 16;
  localparam int N_EVT  = 6;

  localparam int B_TX_END   = 0;
  localparam int B_TX_LWM   = 2;
  localparam int B_RX_HWM   = 4;
  localparam int B_RX_START = 5;
  localparam int B_RX_END   = 6;
  localparam int B_TX_UDR   = 7;
  localparam int B_FILL_LO  = 8;
  localparam int FILL_W     = 4;
  localparam int B_TX_EMPTY = 12;
  localparam int B_RX_OVR   = 13;
  localparam int B_RX_EMPTY = 14;
  localparam int B_RX_ABT   = 15;

  typedef enum logic {SEL_STATUS = 1'b0, SEL_MASK = 1'b1} reg_sel_e;

  // event slot -> status bit position
  function automatic int evt_bit(input int k);
    case (k)
      0:       return B_TX_END;
      1:       return B_RX_START;
      2:       return B_RX_END;
      3:       return B_TX_UDR;
      4:       return B_RX_OVR;
      default: return B_RX_ABT;
    endcase
  endfunction
endpackage

// File: rtl/hdlc_evt_latch.sv
module hdlc_evt_latch #(
  parameter int N = 6
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic         clr_i,
  output logic [N-1:0] q_o
);
  for (genvar k = 0; k < N; k++) begin : g_bit
    // set wins over clear so a colliding event survives
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q_o[k] <= 1'b0;
      else         q_o[k] <= set_i[k] | (q_o[k] & ~clr_i);
    end
  end
endmodule

// File: rtl/hdlc_wm_level.sv
module hdlc_wm_level #(
  parameter int CNT_W   = 8,
  parameter int WM_STEP = 16,
  parameter int FILL_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CNT_W-1:0]  tx_cnt_i,
  input  logic [CNT_W-1:0]  rx_cnt_i,
  input  logic [2:0]        tx_sel_i,
  input  logic [2:0]        rx_sel_i,
  output logic              tx_lwm_o,
  output logic              rx_hwm_o,
  output logic              tx_empty_o,
  output logic              rx_empty_o,
  output logic [FILL_W-1:0] tx_fill_o
);
  localparam int THR_W = CNT_W + $clog2(WM_STEP + 1) + 3;

  logic [THR_W-1:0]  tx_thr, rx_thr;
  logic [FILL_W-1:0] fill_d;

  assign tx_thr = THR_W'(tx_sel_i) * THR_W'(WM_STEP);
  assign rx_thr = THR_W'(rx_sel_i) * THR_W'(WM_STEP);

  if (CNT_W >= FILL_W) begin : g_fill_top
    assign fill_d = tx_cnt_i[CNT_W-1 -: FILL_W];
  end else begin : g_fill_ext
    assign fill_d = FILL_W'(tx_cnt_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_lwm_o   <= 1'b1;
      rx_hwm_o   <= 1'b0;
      tx_empty_o <= 1'b1;
      rx_empty_o <= 1'b1;
      tx_fill_o  <= '0;
    end else begin
      tx_lwm_o   <= THR_W'(tx_cnt_i) < tx_thr;
      rx_hwm_o   <= THR_W'(rx_cnt_i) > rx_thr;
      tx_empty_o <= tx_cnt_i == '0;
      rx_empty_o <= rx_cnt_i == '0;
      tx_fill_o  <= fill_d;
    end
  end
endmodule

// File: rtl/hdlc_irq_merge.sv
module hdlc_irq_merge #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] stat_i,
  input  logic [W-1:0] mask_i,
  input  logic         en_i,
  output logic         irq_o
);
  logic any_hit;
  assign any_hit = |(stat_i & mask_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_o <= 1'b0;
    else         irq_o <= en_i & any_hit;
  end
endmodule

// File: rtl/hdlc_irq_status.sv
module hdlc_irq_status
  import hdlc_stat_pkg::*;
#(
  parameter int CNT_W   = 8,
  parameter int WM_STEP = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_sel_i,
  input  logic              we_i,
  input  logic              re_i,
  input  logic [15:0]       wdata_i,
  output logic [15:0]       rdata_o,
  input  logic              tx_end_evt_i,
  input  logic              tx_udr_evt_i,
  input  logic              rx_start_evt_i,
  input  logic              rx_end_evt_i,
  input  logic              rx_ovr_evt_i,
  input  logic              rx_abt_evt_i,
  input  logic [CNT_W-1:0]  tx_cnt_i,
  input  logic [CNT_W-1:0]  rx_cnt_i,
  input  logic [2:0]        tx_wm_sel_i,
  input  logic [2:0]        rx_wm_sel_i,
  input  logic              hdlc_en_i,
  output logic              irq_o
);
  logic [N_EVT-1:0]  evt_set, evt_q;
  logic              rd_clr;
  logic              tx_lwm, rx_hwm, tx_empty, rx_empty;
  logic [FILL_W-1:0] tx_fill;
  logic [STAT_W-1:0] stat, mask_q, evt_vec;

  assign evt_set = {rx_abt_evt_i, rx_ovr_evt_i, tx_udr_evt_i,
                    rx_end_evt_i, rx_start_evt_i, tx_end_evt_i | tx_udr_evt_i};
  assign rd_clr  = re_i & (reg_sel_e'(reg_sel_i) == SEL_STATUS);

  hdlc_evt_latch #(.N(N_EVT)) u_latch (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (evt_set),
    .clr_i (rd_clr),
    .q_o   (evt_q)
  );

  hdlc_wm_level #(.CNT_W(CNT_W), .WM_STEP(WM_STEP), .FILL_W(FILL_W)) u_level (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tx_cnt_i  (tx_cnt_i),
    .rx_cnt_i  (rx_cnt_i),
    .tx_sel_i  (tx_wm_sel_i),
    .rx_sel_i  (rx_wm_sel_i),
    .tx_lwm_o  (tx_lwm),
    .rx_hwm_o  (rx_hwm),
    .tx_empty_o(tx_empty),
    .rx_empty_o(rx_empty),
    .tx_fill_o (tx_fill)
  );

  for (genvar k = 0; k < STAT_W; k++) begin : g_map
    logic hit;
    always_comb begin
      hit = 1'b0;
      for (int e = 0; e < N_EVT; e++)
        if (evt_bit(e) == k) hit = evt_q[e];
    end
    assign evt_vec[k] = hit;
  end

  always_comb begin
    stat = evt_vec;
    stat[B_TX_LWM]                     = tx_lwm;
    stat[B_RX_HWM]                     = rx_hwm;
    stat[B_TX_EMPTY]                   = tx_empty;
    stat[B_RX_EMPTY]                   = rx_empty;
    stat[B_FILL_LO +: FILL_W]          = tx_fill;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                          mask_q <= '0;
    else if (we_i && reg_sel_e'(reg_sel_i) == SEL_MASK)   mask_q <= wdata_i;
  end

  assign rdata_o = (reg_sel_e'(reg_sel_i) == SEL_MASK) ? mask_q : stat;

  hdlc_irq_merge #(.W(STAT_W)) u_irq (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .stat_i(stat),
    .mask_i(mask_q),
    .en_i  (hdlc_en_i),
    .irq_o (irq_o)
  );
endmodule

// File: rtl/hdlc_irq_status_chk.sv
module hdlc_irq_status_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             reg_sel_i,
  input logic             we_i,
  input logic             re_i,
  input logic             tx_end_evt_i,
  input logic             tx_udr_evt_i,
  input logic             rx_start_evt_i,
  input logic             rx_end_evt_i,
  input logic [CNT_W-1:0] tx_cnt_i,
  input logic             hdlc_en_i,
  input logic [15:0]      stat,
  input logic [15:0]      mask_q,
  input logic             irq_o
);
  // R1
  unused_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stat[3] && !stat[1]);
  // R3
  tx_end_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_end_evt_i || tx_udr_evt_i) |=> stat[0]);
  // R5
  rd_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (re_i && !reg_sel_i && !rx_start_evt_i) |=> !stat[5]);
  // R6
  rd_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (re_i && !reg_sel_i && rx_end_evt_i) |=> stat[6]);
  // R9
  tx_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_cnt_i == '0) |=> stat[12]);
  // R10
  irq_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hdlc_en_i |=> !irq_o);
  // R12
  mask_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_i && reg_sel_i) |=> $stable(mask_q));
endmodule

bind hdlc_irq_status hdlc_irq_status_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .reg_sel_i     (reg_sel_i),
  .we_i          (we_i),
  .re_i          (re_i),
  .tx_end_evt_i  (tx_end_evt_i),
  .tx_udr_evt_i  (tx_udr_evt_i),
  .rx_start_evt_i(rx_start_evt_i),
  .rx_end_evt_i  (rx_end_evt_i),
  .tx_cnt_i      (tx_cnt_i),
  .hdlc_en_i     (hdlc_en_i),
  .stat          (stat),
  .mask_q        (mask_q),
  .irq_o         (irq_o)
);

// File: tb/hdlc_irq_status_test.sv
module hdlc_irq_status_test;
  localparam int CNT_W = 8;
  localparam int STEP  = 16;
  localparam logic [15:0] LAT = 16'hA0E1;

  logic clk = 0, rst_n = 0;
  logic sel = 0, we = 0, re = 0;
  logic [15:0] wd = 0, rdata;
  logic ev_txe = 0, ev_udr = 0, ev_rs = 0, ev_re = 0, ev_ovr = 0, ev_abt = 0;
  logic [CNT_W-1:0] txc = 0, rxc = 0;
  logic [2:0] txs = 0, rxs = 0;
  logic en = 0, irq;

  int checks = 0, fails = 0;
  logic [15:0] m_lat = 0, m_live = 16'h5004, m_mask = 0;
  logic m_irq = 0;

  always #5 clk = ~clk;

  hdlc_irq_status #(.CNT_W(CNT_W), .WM_STEP(STEP)) uut (
    .clk_i(clk), .rst_ni(rst_n), .reg_sel_i(sel), .we_i(we), .re_i(re),
    .wdata_i(wd), .rdata_o(rdata), .tx_end_evt_i(ev_txe), .tx_udr_evt_i(ev_udr),
    .rx_start_evt_i(ev_rs), .rx_end_evt_i(ev_re), .rx_ovr_evt_i(ev_ovr),
    .rx_abt_evt_i(ev_abt), .tx_cnt_i(txc), .rx_cnt_i(rxc), .tx_wm_sel_i(txs),
    .rx_wm_sel_i(rxs), .hdlc_en_i(en), .irq_o(irq));

  task automatic chk(input string t, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", t, act, exp);
    end
  endtask

  function automatic logic [15:0] f_live(input logic [CNT_W-1:0] tc, input logic [CNT_W-1:0] rc,
                                         input logic [2:0] ts, input logic [2:0] rs);
    logic [15:0] v = 0;
    v[2]    = int'(tc) < int'(ts) * STEP;
    v[4]    = int'(rc) > int'(rs) * STEP;
    v[12]   = tc == 0;
    v[14]   = rc == 0;
    v[11:8] = tc[CNT_W-1 -: 4];
    return v;
  endfunction

  function automatic logic [15:0] f_evt();
    logic [15:0] v = 0;
    v[0] = ev_txe | ev_udr; v[7] = ev_udr; v[5] = ev_rs;
    v[6] = ev_re; v[13] = ev_ovr; v[15] = ev_abt;
    return v;
  endfunction

  // called just after a negedge with inputs already driven
  task automatic tick(input string t, input string ti = "R10");
    logic [15:0] stat_now, nlat, nlive, nmask;
    logic nirq;
    #1;
    stat_now = m_lat | m_live;
    chk(t, rdata, sel ? m_mask : stat_now);
    nlat  = (m_lat & ~((re && !sel) ? LAT : 16'h0)) | f_evt();
    nlive = f_live(txc, rxc, txs, rxs);
    nmask = (we && sel) ? wd : m_mask;
    nirq  = en & |(stat_now & m_mask);
    @(posedge clk);
    m_lat = nlat; m_live = nlive; m_mask = nmask; m_irq = nirq;
    @(negedge clk);
    chk(ti, {15'h0, irq}, {15'h0, m_irq});
    {ev_txe, ev_udr, ev_rs, ev_re, ev_ovr, ev_abt} = '0;
    we = 0; re = 0; sel = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog act=running exp=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h1d5e));
    // R2 reset state
    repeat (3) @(negedge clk);
    #1;
    chk("R2", rdata, 16'h5004);
    chk("R2", {15'h0, irq}, 16'h0);
    sel = 1; #1; chk("R2", rdata, 16'h0); sel = 0;
    @(negedge clk); rst_n = 1;
    tick("R2");
    // R12 mask write, status write ignored
    sel = 1; we = 1; wd = 16'hFFFF; tick("R12");
    sel = 1; tick("R12");
    sel = 0; we = 1; wd = 16'hFFFF; tick("R12");
    tick("R12");
    // R1 unused bits
    #1; chk("R1", rdata & 16'h000A, 16'h0);
    // R7 transmit low watermark around threshold 32
    txs = 2; txc = 31; tick("R7"); tick("R7");
    txc = 32; tick("R7"); tick("R7");
    // R8 receive high watermark around threshold 48
    rxs = 3; rxc = 49; tick("R8"); tick("R8");
    rxc = 48; tick("R8"); tick("R8");
    // R9 empty flags and fill field
    txc = 8'hA5; rxc = 0; tick("R9"); tick("R9");
    txc = 0; rxc = 7; tick("R9"); tick("R9");
    // R3 transmit end and underrun
    sel = 1; we = 1; wd = 16'h0001; tick("R3");
    ev_txe = 1; tick("R3"); tick("R3");
    re = 1; tick("R5"); tick("R5");
    ev_udr = 1; tick("R3"); tick("R3");
    re = 1; tick("R5");
    // R4 receive events
    ev_rs = 1; tick("R4"); ev_re = 1; tick("R4");
    ev_ovr = 1; tick("R4"); ev_abt = 1; tick("R4"); tick("R4");
    // R5 read clears, pre-clear value returned
    re = 1; tick("R5"); tick("R5");
    // R6 collision of event and read
    ev_re = 1; tick("R6");
    re = 1; ev_re = 1; tick("R6"); tick("R6");
    // R10 global enable gating
    sel = 1; we = 1; wd = 16'h0020; tick("R10");
    en = 0; ev_rs = 1; tick("R10"); tick("R10"); tick("R10");
    en = 1; tick("R10"); tick("R10");
    // R11 release on read
    re = 1; tick("R11", "R11"); tick("R11", "R11"); tick("R11", "R11");
    // random traffic
    for (int i = 0; i < 600; i++) begin
      ev_txe = ($urandom % 8) == 0; ev_udr = ($urandom % 16) == 0;
      ev_rs  = ($urandom % 8) == 0; ev_re  = ($urandom % 8) == 0;
      ev_ovr = ($urandom % 16) == 0; ev_abt = ($urandom % 16) == 0;
      txc = CNT_W'($urandom); rxc = CNT_W'($urandom);
      if (($urandom % 4) == 0) txc = CNT_W'(txs * STEP - 1 + $urandom % 3);
      txs = 3'($urandom); rxs = 3'($urandom);
      en = ($urandom % 5) != 0;
      sel = ($urandom % 4) == 0;
      re = ($urandom % 4) == 0;
      we = ($urandom % 10) == 0; wd = 16'($urandom);
      tick("R5");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule